// File: doc/BRIEF.md
# Link Quality Threshold Monitor

This block keeps watch over six values that a receiver's adaptive signal processing settles on once a link is up: the equalizer C1 coefficient, the adaptive gain, the baseline wander correction, the long-term recovered-clock frequency offset, the recovered-clock frequency control word and the upper half of the SNR variance sum. Software reads the adapted values first, then programs a window around each one. When a value leaves its window and the monitor is enabled, a sticky warning bit is set. Any set warning can raise an interrupt. A violation on a parameter whose auto-reset enable is set also asks the DSP to restart adaptation, and can ask for the link status to drop.

Software uses three 16-bit registers on a simple strobe bus. Control register A holds the global enable, five auto-reset enables and the ten warnings of the byte-wide parameters. Control register B holds the variance warning and its auto-reset enable. The indirect register samples a parameter's current value, writes a threshold, or selects a threshold for read-back. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `lq_monitor`

## Requirements
- R1: After reset, control register A (address 0) and control register B (address 1) read 0, and `irq`, `dspRestart` and `linkDrop` are 0. Every low threshold sits at its parameter's minimum and every high threshold at its maximum: signed 0x80 and 0x7F, gain 0x00 and 0xFF, variance high 0x900.
- R2: Bit 15 of control register A is the global enable. While it is 0, no warning bit is set, whatever the parameter values are.
- R3: A high warning needs value > high threshold and a low warning needs value < low threshold. Equality raises no warning. Gain (select 001) and variance (select 101) compare unsigned. The other parameters compare as signed two's complement: C1 is 000, wander 010, frequency offset 011, frequency control 100. Variance input stays within 0..0x900.
- R4: Warnings for byte parameter p sit in control register A: low at bit 2p, high at bit 2p+1. The variance high warning is bit 0 of control register B. Variance has no low threshold, so a low write for variance is dropped and its read-back is 0.
- R5: Warning bits are sticky. Reading the register that holds a bit clears it, unless a new violation arrives in the same cycle.
- R6: A write to the indirect register (address 2) with bit 12 set stores data bits [7:0] into the threshold chosen by select bits [11:9] and bit 8 (0 = low, 1 = high). For variance the stored threshold is data shifted left by 4.
- R7: An indirect write with bit 13 set captures the selected parameter's current value. Later reads return it in bits [7:0] (variance: bits [11:4] of its input). The rest of the read word is bit 13 = 1, bits [11:8] = the stored select.
- R8: If the last indirect write had bit 13 clear, an indirect read returns, in bits [7:0], the threshold named by that write's bits [11:8]. The same select echo appears in bits [11:8], and bit 13 is 0.
- R9: `irq` is high exactly while `irqEnable` is 1 and at least one warning bit is set.
- R10: `dspRestart` pulses one cycle after a cycle in which the monitor is enabled and a parameter with its auto-reset enable set is outside its window. Auto-reset enables: control register A bits [14:10] for selects 4..0, control register B bit 1 for variance.
- R11: `linkDrop` pulses together with `dspRestart` when `linkDropOpt` is 0, and stays 0 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 ctrl A, 1 ctrl B, 2 indirect |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid the cycle after the read strobe |
| deqC1 | input | 8 | Equalizer C1 coefficient, signed |
| gainVal | input | 8 | Adaptive gain, unsigned |
| wanderVal | input | 8 | Baseline wander correction, signed |
| freqOffset | input | 8 | Long-term frequency offset, signed |
| freqCtrl | input | 8 | Frequency control word, signed |
| varianceHi | input | 16 | Upper 16 bits of the variance sum, unsigned |
| irqEnable | input | 1 | Interrupt enable |
| linkDropOpt | input | 1 | 0 = violations with auto-reset also drop the link |
| irq | output | 1 | Interrupt request |
| dspRestart | output | 1 | One-cycle DSP adaptation restart request |
| linkDrop | output | 1 | One-cycle link status drop request |

## Verification
The assertions assume that the variance input never goes past 0x900. They also assume that register strobes come one at a time, each with a defined address. The bench keeps every parameter at zero or at a chosen in-range value, and applies each out-of-window value for exactly one clock edge. It returns the value to an in-window level before it reads a register. That way the clear-on-read result and the one-cycle restart pulses can be predicted without a violation arriving in the same cycle.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
  localparam int REG_W    = 16;
  localparam int VAL_W    = 8;
  localparam int N_BYTE   = 5;
  localparam int SEL_W    = 3;
  localparam int VAR_W    = 16;
  localparam int VAR_SHIFT = 4;
  localparam int N_PARAM  = N_BYTE + 1;
  localparam int GAIN_IDX = 1;
  localparam int VAR_IDX  = N_BYTE;
  localparam logic [VAR_W-1:0] VAR_MAX = 16'h0900;

  localparam logic [1:0] ADDR_CTRL_A   = 2'd0;
  localparam logic [1:0] ADDR_CTRL_B   = 2'd1;
  localparam logic [1:0] ADDR_INDIRECT = 2'd2;

  // bit positions inside the indirect register
  localparam int B_SAMPLE = 13;
  localparam int B_THRWR  = 12;
  localparam int B_SELLSB = 9;
  localparam int B_HISEL  = 8;
  localparam int B_ENABLE = 15;
  localparam int B_AUTOLSB = 10;

  typedef struct packed {
    logic             thrWr;
    logic             sampleWr;
    logic             clrWarnA;
    logic             clrWarnB;
    logic [SEL_W-1:0] sel;
    logic             hiSel;
    logic [VAL_W-1:0] data;
  } lqStrobe_t;
endpackage

// File: rtl/lqm_ctrl.sv
module lqm_ctrl
  import lqm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [1:0]            regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic [2*N_BYTE-1:0]   warnByte,
  input  logic                  warnVar,
  input  logic [VAL_W-1:0]      thrRead,
  input  logic [VAL_W-1:0]      sampleVal,
  output lqStrobe_t             stb,
  output logic                  monEnable,
  output logic [N_PARAM-1:0]    autoEn,
  output logic [SEL_W-1:0]      idxSel,
  output logic                  idxHi
);
  logic             sampleMode;
  logic [REG_W-1:0] rdMux;
  logic             indWr;

  assign indWr = regWrEn && (regAddr == ADDR_INDIRECT);

  always_comb begin
    stb          = '0;
    stb.thrWr    = indWr && regWrData[B_THRWR];
    stb.sampleWr = indWr && regWrData[B_SAMPLE];
    stb.sel      = regWrData[B_SELLSB +: SEL_W];
    stb.hiSel    = regWrData[B_HISEL];
    stb.data     = regWrData[VAL_W-1:0];
    stb.clrWarnA = regRdEn && (regAddr == ADDR_CTRL_A);
    stb.clrWarnB = regRdEn && (regAddr == ADDR_CTRL_B);
  end

  always_comb begin
    rdMux = '0;
    case (regAddr)
      ADDR_CTRL_A: begin
        rdMux[B_ENABLE]                = monEnable;
        rdMux[B_AUTOLSB +: N_BYTE]     = autoEn[N_BYTE-1:0];
        rdMux[2*N_BYTE-1:0]            = warnByte;
      end
      ADDR_CTRL_B: begin
        rdMux[1] = autoEn[VAR_IDX];
        rdMux[0] = warnVar;
      end
      ADDR_INDIRECT: begin
        rdMux[B_SAMPLE]             = sampleMode;
        rdMux[B_SELLSB +: SEL_W]    = idxSel;
        rdMux[B_HISEL]              = idxHi;
        rdMux[VAL_W-1:0]            = sampleMode ? sampleVal : thrRead;
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      monEnable  <= 1'b0;
      autoEn     <= '0;
      idxSel     <= '0;
      idxHi      <= 1'b0;
      sampleMode <= 1'b0;
      regRdData  <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          ADDR_CTRL_A: begin
            monEnable          <= regWrData[B_ENABLE];
            autoEn[N_BYTE-1:0] <= regWrData[B_AUTOLSB +: N_BYTE];
          end
          ADDR_CTRL_B: autoEn[VAR_IDX] <= regWrData[1];
          ADDR_INDIRECT: begin
            idxSel     <= regWrData[B_SELLSB +: SEL_W];
            idxHi      <= regWrData[B_HISEL];
            sampleMode <= regWrData[B_SAMPLE];
          end
          default: ;
        endcase
      end
      if (regRdEn) regRdData <= rdMux;
    end
  end

  // R8: a plain address write leaves the next indirect read in threshold mode
  p_addr_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    (indWr && !regWrData[B_SAMPLE]) |=> !sampleMode);

  // bus strobes arrive one at a time with a defined address
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn) && !((regWrEn || regRdEn) && $isunknown(regAddr)));
endmodule

// File: rtl/lqm_datapath.sv
module lqm_datapath
  import lqm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  lqStrobe_t                 stb,
  input  logic                      monEnable,
  input  logic [N_PARAM-1:0]        autoEn,
  input  logic                      linkDropOpt,
  input  logic [N_BYTE*VAL_W-1:0]   byteVals,
  input  logic [VAR_W-1:0]          varUpper,
  input  logic [SEL_W-1:0]          rdSel,
  input  logic                      rdHi,
  output logic [VAL_W-1:0]          thrRead,
  output logic [VAL_W-1:0]          sampleVal,
  output logic [2*N_BYTE-1:0]       warnByte,
  output logic                      warnVar,
  output logic                      dspRestart,
  output logic                      linkDrop
);
  logic [VAL_W-1:0]     loThrArr [N_BYTE];
  logic [VAL_W-1:0]     hiThrArr [N_BYTE];
  logic [VAL_W-1:0]     valArr   [N_BYTE];
  logic [2*N_BYTE-1:0]  hitVec;
  logic [N_PARAM-1:0]   violP;
  logic [VAR_W-1:0]     varThr;
  logic                 varHit;
  logic                 restartNow;

  for (genvar i = 0; i < N_BYTE; i++) begin : g_param
    localparam bit IS_SIGNED = (i != GAIN_IDX);
    localparam logic [VAL_W-1:0] LO_RST = IS_SIGNED ? {1'b1, {(VAL_W-1){1'b0}}} : '0;
    localparam logic [VAL_W-1:0] HI_RST = IS_SIGNED ? {1'b0, {(VAL_W-1){1'b1}}} : '1;
    logic [VAL_W-1:0] val, loThr, hiThr;
    logic             belowLo, aboveHi;

    assign val = byteVals[i*VAL_W +: VAL_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loThr <= LO_RST;
        hiThr <= HI_RST;
      end else if (stb.thrWr && stb.sel == SEL_W'(i)) begin
        if (stb.hiSel) hiThr <= stb.data;
        else           loThr <= stb.data;
      end
    end

    if (IS_SIGNED) begin : g_signed
      assign belowLo = $signed(val) < $signed(loThr);
      assign aboveHi = $signed(val) > $signed(hiThr);
    end else begin : g_unsigned
      assign belowLo = val < loThr;
      assign aboveHi = val > hiThr;
    end

    assign hitVec[2*i]   = belowLo;
    assign hitVec[2*i+1] = aboveHi;
    assign violP[i]      = monEnable && (belowLo || aboveHi);
    assign loThrArr[i]   = loThr;
    assign hiThrArr[i]   = hiThr;
    assign valArr[i]     = val;

    // R3: a high warning never comes from a value equal to its threshold
    p_equal_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(warnByte[2*i+1]) |-> $past(val != hiThr));
    // R3: likewise for the low side
    p_equal_silent_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(warnByte[2*i]) |-> $past(val != loThr));
  end

  always_ff @(posedge clk) begin
    if (!rstN) varThr <= VAR_MAX;
    else if (stb.thrWr && stb.sel == SEL_W'(VAR_IDX) && stb.hiSel)
      varThr <= VAR_W'({stb.data, {VAR_SHIFT{1'b0}}});
  end

  assign varHit         = varUpper > varThr;
  assign violP[VAR_IDX] = monEnable && varHit;
  assign restartNow     = |(violP & autoEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnByte   <= '0;
      warnVar    <= 1'b0;
      dspRestart <= 1'b0;
      linkDrop   <= 1'b0;
    end else begin
      warnByte   <= (stb.clrWarnA ? '0 : warnByte) | (monEnable ? hitVec : '0);
      warnVar    <= (stb.clrWarnB ? 1'b0 : warnVar) | (monEnable && varHit);
      dspRestart <= restartNow;
      linkDrop   <= restartNow && !linkDropOpt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sampleVal <= '0;
    else if (stb.sampleWr) begin
      sampleVal <= '0;
      for (int k = 0; k < N_BYTE; k++)
        if (stb.sel == SEL_W'(k)) sampleVal <= valArr[k];
      if (stb.sel == SEL_W'(VAR_IDX)) sampleVal <= varUpper[VAR_SHIFT +: VAL_W];
    end
  end

  always_comb begin
    thrRead = '0;
    for (int k = 0; k < N_BYTE; k++)
      if (rdSel == SEL_W'(k)) thrRead = rdHi ? hiThrArr[k] : loThrArr[k];
    if (rdSel == SEL_W'(VAR_IDX) && rdHi) thrRead = varThr[VAR_SHIFT +: VAL_W];
  end

  // R2: new warnings only appear after a cycle with the monitor enabled
  p_warn_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((|(warnByte & ~$past(warnByte))) || $rose(warnVar)) |-> $past(monEnable));
  // R5: a warning holds unless its register is read
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (warnVar && !stb.clrWarnB) |=> warnVar);
  // R10: restart only follows an enabled cycle with some auto-reset enable
  p_restart_auto_r10: assert property (@(posedge clk) disable iff (!rstN)
    dspRestart |-> $past(monEnable && (|autoEn)));
  // R11: link drop never comes without a restart request
  p_drop_with_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    linkDrop |-> dspRestart);
  // R3: input assumption on the variance range
  p_var_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    varUpper <= VAR_MAX);
endmodule

// File: rtl/lq_monitor.sv
module lq_monitor
  import lqm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [VAL_W-1:0]  deqC1,
  input  logic [VAL_W-1:0]  gainVal,
  input  logic [VAL_W-1:0]  wanderVal,
  input  logic [VAL_W-1:0]  freqOffset,
  input  logic [VAL_W-1:0]  freqCtrl,
  input  logic [VAR_W-1:0]  varianceHi,
  input  logic              irqEnable,
  input  logic              linkDropOpt,
  output logic              irq,
  output logic              dspRestart,
  output logic              linkDrop
);
  lqStrobe_t           stb;
  logic                monEnable;
  logic [N_PARAM-1:0]  autoEn;
  logic [SEL_W-1:0]    idxSel;
  logic                idxHi;
  logic [VAL_W-1:0]    thrRead, sampleVal;
  logic [2*N_BYTE-1:0] warnByte;
  logic                warnVar;

  lqm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .warnByte(warnByte), .warnVar(warnVar), .thrRead(thrRead),
    .sampleVal(sampleVal), .stb(stb), .monEnable(monEnable),
    .autoEn(autoEn), .idxSel(idxSel), .idxHi(idxHi)
  );

  lqm_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .monEnable(monEnable),
    .autoEn(autoEn), .linkDropOpt(linkDropOpt),
    .byteVals({freqCtrl, freqOffset, wanderVal, gainVal, deqC1}),
    .varUpper(varianceHi), .rdSel(idxSel), .rdHi(idxHi),
    .thrRead(thrRead), .sampleVal(sampleVal), .warnByte(warnByte),
    .warnVar(warnVar), .dspRestart(dspRestart), .linkDrop(linkDrop)
  );

  assign irq = irqEnable && ((|warnByte) || warnVar);

  // R9: with no warning pending the interrupt stays low
  p_irq_needs_warn_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData == regRdData) && !(|warnByte) && !warnVar |-> !irq);
endmodule

// File: tb/test_lq_monitor.sv
module test_lq_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regRdEn;
  logic [1:0]  regAddr;
  logic [15:0] regWrData, regRdData;
  logic [7:0]  deqC1, gainVal, wanderVal, freqOffset, freqCtrl;
  logic [15:0] varianceHi;
  logic        irqEnable, linkDropOpt;
  logic        irq, dspRestart, linkDrop;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lq_monitor i_lq_monitor (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .deqC1(deqC1), .gainVal(gainVal), .wanderVal(wanderVal),
    .freqOffset(freqOffset), .freqCtrl(freqCtrl), .varianceHi(varianceHi),
    .irqEnable(irqEnable), .linkDropOpt(linkDropOpt),
    .irq(irq), .dspRestart(dspRestart), .linkDrop(linkDrop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ind(input bit smp, input bit wr, input int sel,
                                      input bit hi, input logic [7:0] data);
    return {2'b00, smp, wr, sel[2:0], hi, data};
  endfunction

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic clearAll();
    logic [15:0] d;
    rdReg(2'd0, d);
    rdReg(2'd1, d);
  endtask

  // apply one out-of-window value for exactly one edge, handled by caller
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 dspRestart", dspRestart, 0);
    chk("R1 linkDrop", linkDrop, 0);
    rdReg(2'd0, d); chk("R1 ctrlA", d, 16'h0000);
    rdReg(2'd1, d); chk("R1 ctrlB", d, 16'h0000);
    wrReg(2'd2, ind(0, 0, 1, 1, 8'h00)); rdReg(2'd2, d);
    chk("R1 gain high default (R8 readback)", d, 16'h03FF);
    wrReg(2'd2, ind(0, 0, 1, 0, 8'h00)); rdReg(2'd2, d);
    chk("R1 gain low default", d, 16'h0200);
    wrReg(2'd2, ind(0, 0, 2, 0, 8'h00)); rdReg(2'd2, d);
    chk("R1 wander low default", d, 16'h0480);
    wrReg(2'd2, ind(0, 0, 4, 1, 8'h00)); rdReg(2'd2, d);
    chk("R1 freqCtrl high default", d, 16'h097F);
    wrReg(2'd2, ind(0, 0, 5, 1, 8'h00)); rdReg(2'd2, d);
    chk("R1 variance high default", d, 16'h0B90);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wrReg(2'd2, ind(0, 1, 2, 1, 8'd10));   // wander high = 10
    wanderVal = 8'd20; tick(); tick(); wanderVal = 8'd0;
    rdReg(2'd0, d); chk("R2 disabled no warning", d, 16'h0000);
    wrReg(2'd0, 16'h8000);
    wanderVal = 8'd20; tick(); wanderVal = 8'd0;
    rdReg(2'd0, d); chk("R2 R4 wander high bit5", d, 16'h8020);
    rdReg(2'd0, d); chk("R5 cleared by read", d, 16'h8000);
  endtask

  task automatic t_strict();
    logic [15:0] d;
    wrReg(2'd2, 16'h14DA);                 // wander low = -38
    wanderVal = 8'hDA; tick(); wanderVal = 8'd0;
    rdReg(2'd0, d); chk("R3 equal low silent", d & 16'h03FF, 0);
    wanderVal = 8'hD9; tick(); wanderVal = 8'd0;
    rdReg(2'd0, d); chk("R3 R6 wander below -38", d & 16'h03FF, 16'h0010);
    wrReg(2'd2, ind(0, 1, 1, 1, 8'd200));  // gain high = 200
    gainVal = 8'd200; tick(); gainVal = 8'd0;
    rdReg(2'd0, d); chk("R3 gain equal high silent", d & 16'h03FF, 0);
    gainVal = 8'd201; tick(); gainVal = 8'd0;
    rdReg(2'd0, d); chk("R3 gain above high bit3", d & 16'h03FF, 16'h0008);
    gainVal = 8'h80; tick(); gainVal = 8'd0;
    rdReg(2'd0, d); chk("R3 gain unsigned 128 silent", d & 16'h03FF, 0);
    wrReg(2'd2, ind(0, 1, 0, 0, 8'h00));   // C1 low = 0
    deqC1 = 8'hFF; tick(); deqC1 = 8'd0;
    rdReg(2'd0, d); chk("R3 C1 signed -1 below 0 bit0", d & 16'h03FF, 16'h0001);
  endtask

  task automatic t_variance();
    logic [15:0] d;
    wrReg(2'd2, ind(0, 1, 5, 1, 8'h50));   // variance high = 0x500
    wrReg(2'd2, ind(0, 1, 5, 0, 8'h10));   // low write has no target
    wrReg(2'd2, ind(0, 0, 5, 1, 8'h00)); rdReg(2'd2, d);
    chk("R6 variance threshold readback", d, 16'h0B50);
    wrReg(2'd2, ind(0, 0, 5, 0, 8'h00)); rdReg(2'd2, d);
    chk("R4 variance low absent", d, 16'h0A00);
    varianceHi = 16'h0500; tick(); varianceHi = 0;
    rdReg(2'd1, d); chk("R3 variance equal silent", d, 0);
    varianceHi = 16'h0501; tick(); varianceHi = 0;
    rdReg(2'd0, d); chk("R4 variance not in ctrlA", d & 16'h03FF, 0);
    rdReg(2'd1, d); chk("R4 variance warning ctrlB bit0", d, 16'h0001);
    rdReg(2'd1, d); chk("R5 ctrlB cleared", d, 0);
  endtask

  task automatic t_sample();
    logic [15:0] d;
    wanderVal = 8'h33;
    wrReg(2'd2, ind(1, 0, 2, 0, 8'h00));
    wanderVal = 8'h44;
    rdReg(2'd2, d); chk("R7 wander sample held", d, 16'h2433);
    wanderVal = 8'd0;
    varianceHi = 16'h0456;
    wrReg(2'd2, ind(1, 0, 5, 0, 8'h00));
    varianceHi = 0;
    rdReg(2'd2, d); chk("R7 variance sample bits 11:4", d, 16'h2A45);
    wrReg(2'd2, ind(0, 0, 2, 0, 8'h00)); rdReg(2'd2, d);
    chk("R8 back to threshold readback", d, 16'h04DA);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    clearAll();
    irqEnable = 1'b0;
    wanderVal = 8'd20; tick(); wanderVal = 8'd0;
    chk("R9 irq gated off", irq, 0);
    irqEnable = 1'b1; #1;
    chk("R9 irq with warning", irq, 1);
    rdReg(2'd0, d);
    chk("R9 irq after clear", irq, 0);
  endtask

  task automatic t_restart();
    wrReg(2'd0, 16'h9000);                 // enable + wander auto-reset
    linkDropOpt = 1'b1;
    wanderVal = 8'd20; tick();
    chk("R10 restart pulse", dspRestart, 1);
    chk("R11 no drop when opt=1", linkDrop, 0);
    wanderVal = 8'd0; tick();
    chk("R10 restart one cycle", dspRestart, 0);
    linkDropOpt = 1'b0;
    wanderVal = 8'd20; tick();
    chk("R11 drop when opt=0", linkDrop, 1);
    wanderVal = 8'd0; tick();
    chk("R11 drop one cycle", linkDrop, 0);
    wrReg(2'd2, ind(0, 1, 3, 1, 8'd5));    // freqOffset high = 5
    freqOffset = 8'd6; tick(); freqOffset = 8'd0;
    chk("R10 no restart without auto-enable", dspRestart, 0);
    wrReg(2'd1, 16'h0002);                 // variance auto-reset
    varianceHi = 16'h0600; tick(); varianceHi = 0;
    chk("R10 variance restart", dspRestart, 1);
    clearAll();
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    deqC1 = 0; gainVal = 0; wanderVal = 0; freqOffset = 0; freqCtrl = 0;
    varianceHi = 0; irqEnable = 0; linkDropOpt = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_strict();
    t_variance();
    t_sample();
    t_irq();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule